// File: doc/BRIEF.md
# Thirty-two-bit ALU with condition flags

This block is the arithmetic and logic stage of a small processor datapath. It takes two operands, a carry-in bit and a four-bit operation selector. From these it produces a result word and four condition flags: negative, zero, carry and overflow. The block has no clock and no state, so the outputs follow the inputs within the same cycle.

The sixteen operations fall into two groups. The first group is a family of additions and subtractions that all share one adder. These include forms that use the carry-in, forms that swap the operands, and the compare forms. The second group is the bitwise operations, which include the test forms and the move forms.

The compare and test operations drive the result port like any other operation. The surrounding datapath chooses not to write that result back. Operand shifting, register access and instruction decoding are done outside this block.

Top module: `nzcv_alu`

## Requirements
- R1: The bitwise opcodes give these results: 0 gives a AND b, 1 gives a XOR b, 12 gives a OR b, and 14 gives a AND NOT b. The test opcodes give the same results as their bitwise forms: 8 matches opcode 0, and 9 matches opcode 1.
- R2: Opcode 13 gives b and opcode 15 gives NOT b. Operand a has no effect on either.
- R3: Opcodes 4 and 11 give a + b modulo 2^32. Opcode 5 gives a + b + carry-in.
- R4: Opcodes 2 and 10 give a - b, and opcode 3 gives b - a, all modulo 2^32.
- R5: Opcode 6 gives a - b - 1 + carry-in. Opcode 7 gives b - a - 1 + carry-in.
- R6: The zero flag is 1 exactly when all 32 result bits are 0. The negative flag equals result bit 31.
- R7: For opcodes 2 to 7, 10 and 11, the carry flag is the carry out of bit 31 of the sum. For the subtracting forms this means carry is 1 when no borrow occurs, so opcode 10 sets carry exactly when a >= b unsigned.
- R8: For the same arithmetic opcodes, the overflow flag is 1 exactly when the exact signed result lies outside the range -2^31 to 2^31-1.
- R9: For all other opcodes (0, 1, 8, 9, 12, 13, 14, 15), the carry flag equals carry-in and the overflow flag is 0.
- R10: Carry-in has no effect on the result or flags of opcodes 2, 3, 4, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| carry_i | input | 1 | Carry-in, used by the carry arithmetic forms and passed to carry_o for bitwise forms |
| op_i | input | 4 | Operation selector; the codes are listed in R1 to R5 |
| res_o | output | 32 | Operation result |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag (means "no borrow" on subtraction) |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
There is no stored state in this block. A fault therefore shows up at the ports in the same cycle that the faulting input pattern is applied, and it never shows up later.

The most likely faults are these:
- a wrong operand swap or inversion in the adder select, which appears as a wrong result for the reverse or carry subtract forms;
- a wrong carry into a chunk of the adder, which appears only for operand pairs whose carry crosses that chunk boundary;
- a wrong sign comparison, which appears in the overflow flag only at the signed limits.

The bench therefore covers every opcode with both carry-in values, against the corner operands and random pairs.

// File: rtl/nzcv_alu_pkg.sv
package nzcv_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND     = 4'h0,
    OP_XOR     = 4'h1,
    OP_SUB     = 4'h2,
    OP_RSUB    = 4'h3,
    OP_ADD     = 4'h4,
    OP_ADDC    = 4'h5,
    OP_SUBC    = 4'h6,
    OP_RSUBC   = 4'h7,
    OP_TESTAND = 4'h8,
    OP_TESTXOR = 4'h9,
    OP_CMPSUB  = 4'hA,
    OP_CMPADD  = 4'hB,
    OP_OR      = 4'hC,
    OP_MOVE    = 4'hD,
    OP_CLEAR   = 4'hE,
    OP_MOVENOT = 4'hF
  } alu_op_e;

  // Returns 1 for every operation that goes through the shared adder.
  function automatic logic is_arith(alu_op_e op);
    case (op)
      OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC,
      OP_CMPSUB, OP_CMPADD: return 1'b1;
      default:              return 1'b0;
    endcase
  endfunction

  // Returns 1 when the second adder input is inverted (subtract forms).
  function automatic logic inverts_second(alu_op_e op);
    case (op)
      OP_SUB, OP_RSUB, OP_SUBC, OP_RSUBC, OP_CMPSUB: return 1'b1;
      default:                                        return 1'b0;
    endcase
  endfunction

  // Returns 1 when the operands change places before they reach the adder.
  function automatic logic swaps_operands(alu_op_e op);
    return (op == OP_RSUB) || (op == OP_RSUBC);
  endfunction

  // Returns 1 when the adder takes the external carry-in.
  function automatic logic uses_carry_in(alu_op_e op);
    return (op == OP_ADDC) || (op == OP_SUBC) || (op == OP_RSUBC);
  endfunction

endpackage

// File: rtl/nzcv_alu_opsel.sv
module nzcv_alu_opsel
  import nzcv_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] add_x,
  output logic [WIDTH-1:0] add_y,
  output logic             add_c
);

  logic [WIDTH-1:0] second;

  always_comb begin
    add_x  = swaps_operands(op) ? b : a;
    second = swaps_operands(op) ? a : b;
    add_y  = inverts_second(op) ? ~second : second;
    // Plain subtraction adds one; plain addition adds zero.
    add_c  = uses_carry_in(op) ? cin : inverts_second(op);
  end

endmodule

// File: rtl/nzcv_alu_adder.sv
module nzcv_alu_adder #(
  parameter int WIDTH = 32,
  parameter int CHUNK = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  localparam int NCHUNK = WIDTH / CHUNK;

  // Adds one chunk and returns {carry-out, chunk sum}.
  function automatic logic [CHUNK:0] add_chunk(
    input logic [CHUNK-1:0] p,
    input logic [CHUNK-1:0] q,
    input logic             c
  );
    return {1'b0, p} + {1'b0, q} + {{CHUNK{1'b0}}, c};
  endfunction

  logic [NCHUNK:0] chain;

  assign chain[0] = cin;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    logic [CHUNK:0] part;
    assign part = add_chunk(x[g*CHUNK +: CHUNK], y[g*CHUNK +: CHUNK], chain[g]);
    assign sum[g*CHUNK +: CHUNK] = part[CHUNK-1:0];
    assign chain[g+1] = part[CHUNK];
  end

  assign cout = chain[NCHUNK];
  assign ovf  = (x[WIDTH-1] == y[WIDTH-1]) && (sum[WIDTH-1] != x[WIDTH-1]);

endmodule

// File: rtl/nzcv_alu_logic.sv
module nzcv_alu_logic
  import nzcv_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    case (op)
      OP_AND, OP_TESTAND: res = a & b;
      OP_XOR, OP_TESTXOR: res = a ^ b;
      OP_OR:              res = a | b;
      OP_MOVE:            res = b;
      OP_CLEAR:           res = a & ~b;
      OP_MOVENOT:         res = ~b;
      default:            res = '0;
    endcase
  end

endmodule

// File: rtl/nzcv_alu.sv
module nzcv_alu
  import nzcv_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CHUNK = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             ovf_o
);

  alu_op_e          op;
  logic             arith_sel;
  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y;
  logic             add_c;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_ovf;
  logic [WIDTH-1:0] logic_res;

  assign op        = alu_op_e'(op_i);
  assign arith_sel = is_arith(op);

  nzcv_alu_opsel #(.WIDTH(WIDTH)) u_opsel (
    .op    (op),
    .a     (a_i),
    .b     (b_i),
    .cin   (carry_i),
    .add_x (add_x),
    .add_y (add_y),
    .add_c (add_c)
  );

  nzcv_alu_adder #(.WIDTH(WIDTH), .CHUNK(CHUNK)) u_adder (
    .x    (add_x),
    .y    (add_y),
    .cin  (add_c),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  nzcv_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op  (op),
    .a   (a_i),
    .b   (b_i),
    .res (logic_res)
  );

  always_comb begin
    res_o   = arith_sel ? add_sum : logic_res;
    neg_o   = res_o[WIDTH-1];
    zero_o  = ~|res_o;
    carry_o = arith_sel ? add_cout : carry_i;
    ovf_o   = arith_sel & add_ovf;
  end

endmodule

// File: rtl/nzcv_alu_chk.sv
module nzcv_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] res_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o,
  input logic             arith_sel
);

  always_comb begin
    if (!arith_sel) begin
      // R9
      logic_carry_chk: assert (carry_o == carry_i);
      // R9
      logic_ovf_chk: assert (!ovf_o);
    end
    if (op_i == 4'hD) begin
      // R2
      move_chk: assert (res_o == b_i);
    end
    if (op_i == 4'hA) begin
      // R4
      cmp_zero_chk: assert (zero_o == (a_i == b_i));
      // R7
      cmp_carry_chk: assert (carry_o == (a_i >= b_i));
    end
    if (op_i == 4'h4 && a_i[WIDTH-1] != b_i[WIDTH-1]) begin
      // R8
      add_ovf_chk: assert (!ovf_o);
    end
  end

endmodule

bind nzcv_alu nzcv_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .carry_i   (carry_i),
  .op_i      (op_i),
  .res_o     (res_o),
  .carry_o   (carry_o),
  .ovf_o     (ovf_o),
  .zero_o    (zero_o),
  .arith_sel (arith_sel)
);

// File: tb/nzcv_alu_tb.sv
`timescale 1ns/1ps
module nzcv_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic        cin;
  logic [3:0]  op;
  logic [31:0] res;
  logic        n_f, z_f, c_f, v_f;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  nzcv_alu u_dut (
    .a_i(a), .b_i(b), .carry_i(cin), .op_i(op),
    .res_o(res), .neg_o(n_f), .zero_o(z_f), .carry_o(c_f), .ovf_o(v_f)
  );

  function automatic string tag_of(int o);
    case (o)
      0, 1, 8, 9, 12, 14: return "R1";
      13, 15:             return "R2";
      4, 5, 11:           return "R3";
      2, 3, 10:           return "R4";
      default:            return "R5";
    endcase
  endfunction

  // Behavioural model: exact integer arithmetic, then wrap and range tests.
  task automatic ref_model(input int o, input logic [31:0] x, input logic [31:0] y,
                           input logic ci, output logic [31:0] r, output logic ec,
                           output logic ev);
    longint ux = longint'(x);
    longint uy = longint'(y);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint u = 0, s = 0;
    longint brw = ci ? 0 : 1;
    bit arith = 1'b1, sub = 1'b1;
    case (o)
      4, 11: begin u = ux + uy; s = sx + sy; sub = 0; end
      5:     begin u = ux + uy + longint'(ci); s = sx + sy + longint'(ci); sub = 0; end
      2, 10: begin u = ux - uy; s = sx - sy; end
      3:     begin u = uy - ux; s = sy - sx; end
      6:     begin u = ux - uy - brw; s = sx - sy - brw; end
      7:     begin u = uy - ux - brw; s = sy - sx - brw; end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      r  = u[31:0];
      ec = sub ? (u >= 0) : (u > 64'sd4294967295);
      ev = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (o)
        0, 8:  r = x & y;
        1, 9:  r = x ^ y;
        12:    r = x | y;
        13:    r = y;
        14:    r = x & ~y;
        default: r = ~y;
      endcase
      ec = ci;
      ev = 1'b0;
    end
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (op %0d a %h b %h cin %0b)",
               tag, what, act, exp, op, a, b, cin);
    end
  endtask

  task automatic apply(input int o, input logic [31:0] x, input logic [31:0] y,
                       input logic ci);
    logic [31:0] er;
    logic ec, ev;
    @(posedge clk);
    #1;
    op = o[3:0]; a = x; b = y; cin = ci;
    @(negedge clk);
    ref_model(o, x, y, ci, er, ec, ev);
    check(tag_of(o), "result", res, er);
    check("R6", "zero", {31'b0, z_f}, {31'b0, er == 32'd0});
    check("R6", "negative", {31'b0, n_f}, {31'b0, er[31]});
    check((o inside {0, 1, 8, 9, 12, 13, 14, 15}) ? "R9" : "R7", "carry",
          {31'b0, c_f}, {31'b0, ec});
    check((o inside {0, 1, 8, 9, 12, 13, 14, 15}) ? "R9" : "R8", "overflow",
          {31'b0, v_f}, {31'b0, ev});
  endtask

  logic [31:0] corners [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                               32'hFFFF_FFFF, 32'h00FF_FF00};

  initial begin
    op = 4'h0; a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle pattern: AND of zeros gives zero result, Z set (R1, R6)
    check("R1", "idle result", res, 32'h0);
    check("R6", "idle zero", {31'b0, z_f}, 32'h1);

    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int c = 0; c < 2; c++)
            apply(o, corners[i], corners[j], c[0]);

    for (int k = 0; k < 2000; k++)
      apply(k % 16, $urandom, $urandom, $urandom_range(0, 1));

    // R10: carry-in must not change the non-carry arithmetic forms
    foreach (corners[i]) begin
      foreach (corners[j]) begin
        for (int s = 0; s < 5; s++) begin
          int o;
          logic [31:0] r0;
          logic c0, v0;
          o = (s == 0) ? 2 : (s == 1) ? 3 : (s == 2) ? 4 : (s == 3) ? 10 : 11;
          apply(o, corners[i], corners[j], 1'b0);
          r0 = res; c0 = c_f; v0 = v_f;
          apply(o, corners[i], corners[j], 1'b1);
          check("R10", "cin-free result", res, r0);
          check("R10", "cin-free flags", {30'b0, c_f, v_f}, {30'b0, c0, v0});
        end
      end
    end

    // R2: operand a must not affect the move forms
    apply(13, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
    check("R2", "move ignores a", res, 32'h1234_5678);
    apply(15, 32'h0BAD_F00D, 32'h0000_FFFF, 1'b1);
    check("R2", "move-not ignores a", res, 32'hFFFF_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule